// File: doc/BRIEF.md
# Paged Address Translator

This block turns a 16-bit virtual address into a 22-bit physical address. The virtual space is cut into eight pages, and each page is made of 64-byte blocks. Every page has a base register, which holds the physical block number where the page starts. Every page also has a descriptor register, which holds the page length, the expansion direction and a 2-bit access code. There are two full sets of these registers. Kernel mode (mode 0) uses one set and user mode (mode 3) uses the other. Modes 1 and 2 are illegal and always abort.

Software reaches the registers through a small word-wide port. Reads are combinational and writes take effect at the clock edge. Translation requests carry a virtual address, a read/write flag and the current mode. One cycle later the block answers with either a physical address or an abort. The first abort records its causes, its page, its mode and the virtual address in two status registers. That record stays frozen until software clears the abort bits. When relocation is switched off in status register 0, addresses pass straight through with no checks.

Top module: `vpage_mmu`

## Requirements
- R1: Register map on `reg_addr`. When bit 5 is 0, the address selects a page register: bit 4 picks the set (0 kernel, 1 user), bit 3 picks base (0) or descriptor (1), and bits 2:0 give the page. Address 0x20 is status 0, whose writable bits are 15:13, 6:5, 3:1 and 0. Address 0x21 is status 2, which is read-only. Every other address reads 0. All registers reset to 0.
- R2: A descriptor keeps only the length in bits 14:8, the written flag in bit 6, the downward flag in bit 3 and the access code in bits 2:1. Bits 15, 7, 5, 4 and 0 read as 0. A software write always leaves bit 6 clear.
- R3: When status 0 bit 0 is 0, `rsp_pa` equals the zero-extended virtual address, `rsp_abort` is 0, and status 0 and status 2 do not change, whatever the mode or direction.
- R4: `rsp_valid` rises exactly one cycle after `req_valid`. On success, `rsp_pa` = ((base + block) * 64 + offset) mod 2^22. The block number is virtual address bits 12:6, the offset is bits 5:0, and the page is bits 15:13. On abort, `rsp_pa` is 0.
- R5: Access codes. 00 and 10 abort every access and flag non-resident (status 0 bit 15). 01 allows reads but aborts writes and flags read-only (bit 13). 11 allows reads and writes.
- R6: Page length check. With descriptor bit 3 clear (upward), the access is legal when block ≤ length. With bit 3 set (downward), it is legal when block ≥ length. A violation aborts and flags page length (status 0 bit 14).
- R7: Mode 0 uses the kernel set and mode 3 uses the user set. Modes 1 and 2 abort with the non-resident flag, whatever the descriptors hold.
- R8: An abort while status 0 bits 15:13 are all 0 does four things: it loads the cause bits, writes the page into bits 3:1, writes the mode into bits 6:5, and puts the virtual address in status 2. Later aborts change nothing until software clears bits 15:13. A software write to status 0 in the same cycle as an abort takes precedence for status 0.
- R9: A relocated write that does not abort sets bit 6 of that page's descriptor. A software write to that page's base or descriptor clears bit 6, even if a write access hits the page in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register select (map in R1) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request |
| req_va | input | 16 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_mode | input | 2 | Current mode: 0 kernel, 3 user |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_pa | output | 22 | Physical address |
| rsp_abort | output | 1 | Access aborted |

## Verification
The assertions assume that `req_valid`, `req_mode` and the register strobe are known values whenever reset is released. They also assume that a status-0 write and a fault in the same cycle resolve with software winning. No other ordering is taken for granted. The stimulus is built to respect this and to reach the interesting cases. Directed steps set up each access code, both length directions and every mode, and they clear the abort bits between faults so that each capture can be seen. A long random phase follows, in which status-0 writes mostly keep relocation on. The bench model resolves same-cycle collisions with the same precedence as R8 and R9, so random collisions stay within what the assertions expect.

// File: rtl/vpage_pkg.sv
// Package vpage_pkg
// Shared encodings for the paged translator: access codes, fault flags and
// the bit positions of the descriptor and status words.
package vpage_pkg;

    typedef enum logic [1:0] {
        ACC_ABSENT = 2'b00,
        ACC_RDONLY = 2'b01,
        ACC_TRAP   = 2'b10,
        ACC_RDWR   = 2'b11
    } acc_e;

    typedef struct packed {
        logic absent;
        logic length;
        logic rdonly;
    } fault_t;

    localparam int DSC_LEN_LSB  = 8;
    localparam int DSC_WR_BIT   = 6;
    localparam int DSC_DOWN_BIT = 3;
    localparam int DSC_ACC_LSB  = 1;

    localparam int ST_EN_BIT    = 0;
    localparam int ST_PAGE_LSB  = 1;
    localparam int ST_MODE_LSB  = 5;
    localparam int ST_RO_BIT    = 13;
    localparam int ST_LEN_BIT   = 14;
    localparam int ST_NR_BIT    = 15;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
    localparam logic [1:0] MODE_USER   = 2'd3;

endpackage

// File: rtl/vpage_regfile.sv
// Module vpage_regfile
// Holds the base and descriptor registers of both mode sets. The entry index
// is {set, page}. It provides one lookup port for translation, one read port
// for software and one write port for software, plus a mark input that sets
// the written flag.
// Assumes: the descriptor fields fit the word layout given in vpage_pkg.
module vpage_regfile
    import vpage_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int REG_W  = 16,
    parameter int BN_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [PAGE_W:0]   sw_idx,
    input  logic              sw_desc,
    input  logic [REG_W-1:0]  sw_wdata,
    input  logic [PAGE_W:0]   lk_idx,
    output logic [REG_W-1:0]  lk_base,
    output logic [REG_W-1:0]  lk_desc,
    input  logic              mark_we,
    input  logic [PAGE_W:0]   mark_idx,
    input  logic [PAGE_W:0]   rd_idx,
    input  logic              rd_desc,
    output logic [REG_W-1:0]  rd_data
);
    localparam int IDX_W   = PAGE_W + 1;
    localparam int ENTRIES = 2 ** IDX_W;

    logic [ENTRIES-1:0][REG_W-1:0] base_q;
    logic [ENTRIES-1:0][BN_W-1:0]  len_q;
    logic [ENTRIES-1:0][1:0]       acc_q;
    logic [ENTRIES-1:0]            down_q;
    logic [ENTRIES-1:0]            wr_q;
    logic [ENTRIES-1:0][REG_W-1:0] desc_w;

    // Register storage: a software write wins over a written-flag mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            acc_q  <= '0;
            down_q <= '0;
            wr_q   <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (sw_we && sw_idx == IDX_W'(i)) begin
                    if (sw_desc) begin
                        len_q[i]  <= sw_wdata[DSC_LEN_LSB +: BN_W];
                        down_q[i] <= sw_wdata[DSC_DOWN_BIT];
                        acc_q[i]  <= sw_wdata[DSC_ACC_LSB +: 2];
                    end else begin
                        base_q[i] <= sw_wdata;
                    end
                    wr_q[i] <= 1'b0;
                end else if (mark_we && mark_idx == IDX_W'(i)) begin
                    wr_q[i] <= 1'b1;
                end
            end
        end
    end

    // Pack each descriptor word; unused bit positions are tied to zero.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign desc_w[g] = REG_W'({1'b0, len_q[g], 1'b0, wr_q[g], 2'b00,
                                   down_q[g], acc_q[g], 1'b0});

        // R9: a software write to this entry leaves its written flag clear
        a_r9_wbit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_we && sw_idx == IDX_W'(g)) |=> !wr_q[g]);
    end

    // Lookup and read muxes.
    assign lk_base = base_q[lk_idx];
    assign lk_desc = desc_w[lk_idx];
    assign rd_data = rd_desc ? desc_w[rd_idx] : base_q[rd_idx];

endmodule

// File: rtl/vpage_check.sv
// Module vpage_check
// Combinational check and relocation for one access. It decodes the access
// code, checks the block number against the page length in the chosen
// direction, rejects illegal modes, and forms the relocated address.
// Assumes: base and desc already come from the set that matches the mode.
module vpage_check
    import vpage_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int PA_W   = 22,
    parameter int OFF_W  = 6,
    parameter int PAGE_W = 3,
    parameter int REG_W  = 16,
    parameter int BN_W   = 7
) (
    input  logic [VA_W-1:0]   va,
    input  logic              write,
    input  logic [1:0]        mode,
    input  logic [REG_W-1:0]  base,
    input  logic [REG_W-1:0]  desc,
    output logic [PAGE_W-1:0] page,
    output logic [PA_W-1:0]   pa,
    output fault_t            flt
);
    logic            illegal;
    logic            beyond;
    acc_e            acc;
    logic [BN_W-1:0] bn;
    logic [BN_W-1:0] len;
    logic [PA_W-1:0] frame;
    logic            unused_desc;

    assign unused_desc = ^{desc[REG_W-1], desc[7:4], desc[0]};
    assign page        = va[VA_W-1 -: PAGE_W];

    // Fault decode and physical address formation.
    always_comb begin
        illegal    = (mode != MODE_KERNEL) && (mode != MODE_USER);
        acc        = acc_e'(desc[DSC_ACC_LSB +: 2]);
        bn         = va[OFF_W +: BN_W];
        len        = desc[DSC_LEN_LSB +: BN_W];
        beyond     = desc[DSC_DOWN_BIT] ? (bn < len) : (bn > len);
        flt.absent = illegal || acc == ACC_ABSENT || acc == ACC_TRAP;
        flt.rdonly = !illegal && acc == ACC_RDONLY && write;
        flt.length = !illegal && beyond;
        frame      = PA_W'(base) + PA_W'(bn);
        pa         = (frame << OFF_W) | PA_W'(va[OFF_W-1:0]);
    end

endmodule

// File: rtl/vpage_status.sv
// Module vpage_status
// Status register 0 holds the enable bit and the fault record. Status
// register 2 holds the faulting virtual address. The first fault is captured
// only while no abort bit is pending. A software write to status 0 overrides
// a capture that happens in the same cycle.
// Assumes: flt_valid is asserted only for relocated requests.
module vpage_status
    import vpage_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int REG_W  = 16,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  fault_t            flt,
    input  logic [PAGE_W-1:0] flt_page,
    input  logic [1:0]        flt_mode,
    input  logic [VA_W-1:0]   flt_va,
    input  logic              sw_we,
    input  logic [REG_W-1:0]  sw_wdata,
    output logic              reloc_en,
    output logic [REG_W-1:0]  sr0,
    output logic [VA_W-1:0]   sr2
);
    localparam logic [REG_W-1:0] ST_MASK = REG_W'(16'hE06F);

    logic [REG_W-1:0] sr0_q;
    logic [VA_W-1:0]  sr2_q;
    logic             pending;
    logic             capture;

    assign pending = sr0_q[ST_NR_BIT] | sr0_q[ST_LEN_BIT] | sr0_q[ST_RO_BIT];
    assign capture = flt_valid && (|flt) && !pending;

    // Fault capture, then the software write that overrides it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr0_q <= '0;
            sr2_q <= '0;
        end else begin
            if (capture) begin
                sr0_q[ST_NR_BIT]                <= flt.absent;
                sr0_q[ST_LEN_BIT]               <= flt.length;
                sr0_q[ST_RO_BIT]                <= flt.rdonly;
                sr0_q[ST_MODE_LSB +: 2]         <= flt_mode;
                sr0_q[ST_PAGE_LSB +: PAGE_W]    <= flt_page;
                sr2_q                           <= flt_va;
            end
            if (sw_we) begin
                sr0_q <= sw_wdata & ST_MASK;
            end
        end
    end

    assign reloc_en = sr0_q[ST_EN_BIT];
    assign sr0      = sr0_q;
    assign sr2      = sr2_q;

    // R8: while an abort is pending, the recorded page and mode hold
    a_r8_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !sw_we) |=> $stable(sr0_q[6:1]));

    // R8: while an abort is pending, the recorded virtual address holds
    a_r8_va_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(sr2_q));

endmodule

// File: rtl/vpage_mmu.sv
// Module vpage_mmu
// Top of the paged translator. It decodes the register port, looks up the
// page pair for the requested mode, checks and relocates the access, marks
// written pages and registers the response one cycle after the request.
// Assumes: ADDR_W = PAGE_W + 3, which gives the register map of the brief.
module vpage_mmu
    import vpage_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int PA_W   = 22,
    parameter int OFF_W  = 6,
    parameter int PAGE_W = 3,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_abort
);
    localparam int BN_W   = VA_W - PAGE_W - OFF_W;
    localparam int ADDR_W = PAGE_W + 3;
    localparam logic [ADDR_W-1:0] ADR_ST0 = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] ADR_ST2 = ADR_ST0 | ADDR_W'(1);

    logic              page_hit;
    logic [PAGE_W:0]   sw_idx;
    logic [PAGE_W:0]   lk_idx;
    logic [REG_W-1:0]  lk_base;
    logic [REG_W-1:0]  lk_desc;
    logic [REG_W-1:0]  pg_rdata;
    logic [REG_W-1:0]  sr0;
    logic [VA_W-1:0]   sr2;
    logic              reloc_en;
    logic              mark_we;
    logic              st0_we;
    logic              hit_abort;
    logic [PAGE_W-1:0] page;
    logic [PA_W-1:0]   pa;
    fault_t            flt;

    assign page_hit  = !reg_addr[ADDR_W-1];
    assign sw_idx    = {reg_addr[PAGE_W+1], reg_addr[PAGE_W-1:0]};
    assign lk_idx    = {req_mode == MODE_USER, req_va[VA_W-1 -: PAGE_W]};
    assign st0_we    = reg_we && reg_addr == ADR_ST0;
    assign hit_abort = req_valid && reloc_en && (|flt);
    assign mark_we   = req_valid && reloc_en && req_write && !(|flt);

    vpage_regfile #(.PAGE_W(PAGE_W), .REG_W(REG_W), .BN_W(BN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (reg_we && page_hit),
        .sw_idx   (sw_idx),
        .sw_desc  (reg_addr[PAGE_W]),
        .sw_wdata (reg_wdata),
        .lk_idx   (lk_idx),
        .lk_base  (lk_base),
        .lk_desc  (lk_desc),
        .mark_we  (mark_we),
        .mark_idx (lk_idx),
        .rd_idx   (sw_idx),
        .rd_desc  (reg_addr[PAGE_W]),
        .rd_data  (pg_rdata)
    );

    vpage_check #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
                  .REG_W(REG_W), .BN_W(BN_W)) u_check (
        .va    (req_va),
        .write (req_write),
        .mode  (req_mode),
        .base  (lk_base),
        .desc  (lk_desc),
        .page  (page),
        .pa    (pa),
        .flt   (flt)
    );

    vpage_status #(.VA_W(VA_W), .REG_W(REG_W), .PAGE_W(PAGE_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .flt_valid (req_valid && reloc_en),
        .flt       (flt),
        .flt_page  (page),
        .flt_mode  (req_mode),
        .flt_va    (req_va),
        .sw_we     (st0_we),
        .sw_wdata  (reg_wdata),
        .reloc_en  (reloc_en),
        .sr0       (sr0),
        .sr2       (sr2)
    );

    // Software read mux over page registers and status words.
    always_comb begin
        if (page_hit)                  reg_rdata = pg_rdata;
        else if (reg_addr == ADR_ST0)  reg_rdata = sr0;
        else if (reg_addr == ADR_ST2)  reg_rdata = REG_W'(sr2);
        else                           reg_rdata = '0;
    end

    // Response register: one cycle of latency for every request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_abort <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_abort <= hit_abort;
            if (!req_valid || hit_abort) rsp_pa <= '0;
            else if (!reloc_en)          rsp_pa <= PA_W'(req_va);
            else                         rsp_pa <= pa;
        end
    end

    // R4: every request gets a response on the next cycle
    a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4: no response without a request
    a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: with relocation off, the address passes through unchecked
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !reloc_en) |=>
            (!rsp_abort && rsp_pa == PA_W'($past(req_va))));

    // R7: illegal modes always abort when relocating
    a_r7_illegal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && reloc_en && req_mode != MODE_KERNEL
         && req_mode != MODE_USER) |=> rsp_abort);

endmodule

// File: tb/tb_vpage_mmu.sv
`timescale 1ns/1ps
module tb_vpage_mmu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        req_valid;
    logic [15:0] req_va;
    logic        req_write;
    logic [1:0]  req_mode;
    logic        rsp_valid;
    logic [21:0] rsp_pa;
    logic        rsp_abort;

    always #10 clk = ~clk;

    vpage_mmu dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_va(req_va), .req_write(req_write), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort)
    );

    // Reference model state
    logic [15:0] m_base [16];
    logic [15:0] m_desc [16];
    logic [15:0] m_sr0;
    logic [15:0] m_sr2;
    logic        exp_valid;
    logic        exp_abort;
    logic [21:0] exp_pa;
    string       prev_tag;
    int          n_chk = 0;
    int          n_fail = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [5:0] a);
        if (!a[5]) return a[3] ? m_desc[{a[4], a[2:0]}] : m_base[{a[4], a[2:0]}];
        if (a == 6'h20) return m_sr0;
        if (a == 6'h21) return m_sr2;
        return 16'h0000;
    endfunction

    // Model one clock: response from the present state, then state update.
    task automatic m_step(input logic we, input logic [5:0] a, input logic [15:0] wd,
                          input logic rq, input logic [15:0] va, input logic wr,
                          input logic [1:0] md);
        int idx; int bn; int len; int off; int val;
        logic [1:0] acc;
        bit illegal, nr, ro, ln, ab;
        exp_valid = rq; exp_abort = 1'b0; exp_pa = '0;
        if (rq) begin
            if (!m_sr0[0]) begin
                exp_pa = {6'd0, va};
            end else begin
                idx = (md == 2'd3 ? 8 : 0) + int'(va[15:13]);
                illegal = (md == 2'd1) || (md == 2'd2);
                bn = int'(va[12:6]); off = int'(va[5:0]);
                len = int'(m_desc[idx][14:8]); acc = m_desc[idx][2:1];
                nr = illegal || acc == 2'd0 || acc == 2'd2;
                ro = !illegal && acc == 2'd1 && wr;
                ln = !illegal && (m_desc[idx][3] ? bn < len : bn > len);
                ab = nr | ro | ln;
                exp_abort = ab;
                if (!ab) begin
                    val = (int'(m_base[idx]) + bn) * 64 + off;
                    exp_pa = val[21:0];
                end
                if (ab && m_sr0[15:13] == 3'b000) begin
                    m_sr0[15] = nr; m_sr0[14] = ln; m_sr0[13] = ro;
                    m_sr0[6:5] = md; m_sr0[3:1] = va[15:13];
                    m_sr2 = va;
                end
                if (!ab && wr) m_desc[idx][6] = 1'b1;
            end
        end
        if (we) begin
            if (!a[5]) begin
                idx = int'({a[4], a[2:0]});
                if (a[3]) m_desc[idx] = wd & 16'h7F0E;
                else begin m_base[idx] = wd; m_desc[idx][6] = 1'b0; end
            end else if (a == 6'h20) begin
                m_sr0 = wd & 16'hE06F;
            end
        end
    endtask

    // One cycle: check last response, drive, check read data, advance model.
    task automatic cyc(input logic we, input logic [5:0] a, input logic [15:0] wd,
                       input logic rq, input logic [15:0] va, input logic wr,
                       input logic [1:0] md, input string tag);
        @(negedge clk);
        check(prev_tag, "rsp_valid", 32'(rsp_valid), 32'(exp_valid));
        if (exp_valid) begin
            check(prev_tag, "rsp_abort", 32'(rsp_abort), 32'(exp_abort));
            check(prev_tag, "rsp_pa", 32'(rsp_pa), 32'(exp_pa));
        end
        reg_we = we; reg_addr = a; reg_wdata = wd;
        req_valid = rq; req_va = va; req_write = wr; req_mode = md;
        #1;
        check(tag, "reg_rdata", 32'(reg_rdata), 32'(m_read(a)));
        m_step(we, a, wd, rq, va, wr, md);
        prev_tag = tag;
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [15:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, 16'h0, 1'b0, 2'd0, tag);
    endtask

    task automatic rd_reg(input logic [5:0] a, input string tag);
        cyc(1'b0, a, 16'h0, 1'b0, 16'h0, 1'b0, 2'd0, tag);
    endtask

    task automatic xl(input logic [15:0] va, input logic wr, input logic [1:0] md,
                      input string tag);
        cyc(1'b0, 6'h20, 16'h0, 1'b1, va, wr, md, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_desc[i] = '0; end
        m_sr0 = '0; m_sr2 = '0; exp_valid = 1'b0; exp_abort = 1'b0; exp_pa = '0;
        prev_tag = "R4";
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_mode = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and map
        rd_reg(6'h20, "R1"); rd_reg(6'h08, "R1"); rd_reg(6'h21, "R1"); rd_reg(6'h2A, "R1");
        // R3: pass-through while disabled
        xl(16'hABCD, 1'b0, 2'd0, "R3");
        xl(16'hFFFF, 1'b1, 2'd2, "R3");
        rd_reg(6'h20, "R3"); rd_reg(6'h21, "R3");
        // R1: status 0 writable mask, status 2 read-only
        wr_reg(6'h20, 16'hFFFF, "R1"); rd_reg(6'h20, "R1");
        wr_reg(6'h21, 16'h1234, "R1"); rd_reg(6'h21, "R1");
        wr_reg(6'h20, 16'h0001, "R1");
        // R2: descriptor stores only its fields
        wr_reg(6'h01, 16'h1234, "R4");
        wr_reg(6'h09, 16'h85F7, "R2"); rd_reg(6'h09, "R2");
        // R4 and R6: upward page, length 5
        xl(16'h20D5, 1'b0, 2'd0, "R4");
        xl(16'h2000 | (16'd5 << 6) | 16'h3F, 1'b0, 2'd0, "R6");
        xl(16'h2000 | (16'd6 << 6), 1'b0, 2'd0, "R6");
        rd_reg(6'h20, "R8"); rd_reg(6'h21, "R8");
        // R8: second abort leaves the record frozen
        xl(16'h4000, 1'b1, 2'd3, "R8");
        rd_reg(6'h20, "R8"); rd_reg(6'h21, "R8");
        wr_reg(6'h20, 16'h0001, "R8"); rd_reg(6'h20, "R8");
        // R8: software write beats a same-cycle fault
        cyc(1'b1, 6'h20, 16'h0001, 1'b1, 16'h2000 | (16'd9 << 6), 1'b0, 2'd0, "R8");
        rd_reg(6'h20, "R8");
        // R6: downward page, length 120
        wr_reg(6'h02, 16'hF000, "R6"); wr_reg(6'h0A, 16'h780E, "R6");
        xl(16'h4000 | (16'd119 << 6) | 16'h7, 1'b0, 2'd0, "R6");
        rd_reg(6'h20, "R6");
        wr_reg(6'h20, 16'h0001, "R6");
        xl(16'h4000 | (16'd120 << 6) | 16'h7, 1'b0, 2'd0, "R6");
        xl(16'h4000 | (16'd127 << 6) | 16'h3F, 1'b1, 2'd0, "R6");
        // R5: access codes on kernel page 3
        wr_reg(6'h03, 16'h0200, "R5");
        wr_reg(6'h0B, 16'h7F00, "R5"); xl(16'h6000, 1'b0, 2'd0, "R5");
        rd_reg(6'h20, "R5"); wr_reg(6'h20, 16'h0001, "R5");
        wr_reg(6'h0B, 16'h7F02, "R5"); xl(16'h6044, 1'b0, 2'd0, "R5");
        xl(16'h6044, 1'b1, 2'd0, "R5"); rd_reg(6'h20, "R5");
        wr_reg(6'h20, 16'h0001, "R5");
        wr_reg(6'h0B, 16'h7F04, "R5"); xl(16'h6000, 1'b0, 2'd0, "R5");
        rd_reg(6'h20, "R5"); wr_reg(6'h20, 16'h0001, "R5");
        wr_reg(6'h0B, 16'h7F06, "R5"); xl(16'h7FFF, 1'b1, 2'd0, "R5");
        // R7: mode selects the set; illegal modes abort
        wr_reg(6'h11, 16'h0100, "R7"); wr_reg(6'h19, 16'h7F06, "R7");
        xl(16'h2000, 1'b0, 2'd3, "R7");
        xl(16'h2000, 1'b0, 2'd1, "R7"); rd_reg(6'h20, "R7");
        wr_reg(6'h20, 16'h0001, "R7");
        xl(16'h2000, 1'b0, 2'd2, "R7"); rd_reg(6'h20, "R7");
        wr_reg(6'h20, 16'h0001, "R7");
        // R9: written flag
        rd_reg(6'h09, "R9");
        xl(16'h2040, 1'b1, 2'd0, "R9");
        rd_reg(6'h09, "R9"); rd_reg(6'h19, "R9");
        wr_reg(6'h01, 16'h1234, "R9"); rd_reg(6'h09, "R9");
        xl(16'h2040, 1'b1, 2'd0, "R9");
        cyc(1'b1, 6'h09, 16'h0506, 1'b1, 16'h2040, 1'b1, 2'd0, "R9");
        rd_reg(6'h09, "R9");
        // R4: frame sum wraps past 22 bits
        wr_reg(6'h01, 16'hFFFF, "R4");
        xl(16'h2000 | (16'd5 << 6) | 16'h1, 1'b0, 2'd0, "R4");
        // R3: disable again, checks skipped
        wr_reg(6'h20, 16'h0000, "R3");
        xl(16'h4000 | (16'd119 << 6), 1'b0, 2'd0, "R3");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [5:0]  a;
            logic [15:0] wd;
            int r;
            r  = int'($urandom % 34);
            a  = (r < 32) ? 6'(r) : (r == 32 ? 6'h20 : 6'h21);
            wd = 16'($urandom);
            if (a == 6'h20) wd[0] = (($urandom % 5) != 0);
            cyc(($urandom % 4) == 0, a, wd, 1'($urandom), 16'($urandom),
                1'($urandom), 2'($urandom), "R4");
        end
        rd_reg(6'h20, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule